// File: doc/BRIEF.md
# Serial Command Word Transmitter

This block is a serial-bus master with a single job. It sends one 16-bit command frame to a peripheral. The frame joins a 4-bit command code and a 12-bit data value. The serial clock runs at a fixed fraction of the system clock. The select line is driven low for the length of one frame and released after every frame. Between frames a guard interval is enforced, so the peripheral always sees a clean select pulse.

The host drives `cmd` and `data` and raises `start_req`. The request is taken on the first rising edge at which the block is idle, and the command and data are captured on that edge. `busy` stays high from that edge until the guard interval after the frame has elapsed. Requests that arrive while `busy` is high are dropped. A request held high across the end of a frame is taken as soon as `busy` falls.

Top module: `spi_cmd_tx`

## Requirements
- R1: The frame is `{cmd, data}`. Command bits 3..0 go out as frame bits 15..12 and data bits 11..0 as frame bits 11..0. Frame bit 15 is shifted first and bit 0 last.
- R2: After reset, and whenever no frame is in flight, `cs_n`=1, `sclk`=0, `mosi`=0 and `busy`=0. `sclk` is never high while `cs_n` is high.
- R3: While `cs_n` is low, `mosi` changes only on the system clock edge where `sclk` falls, so it is stable at each rising `sclk` edge (clock idles low, capture on the first edge).
- R4: `sclk` has a period of `SCK_DIV`=6 system clocks, high for 3 and low for 3. Each frame has exactly 16 rising edges.
- R5: The first rising `sclk` edge comes `CS_SETUP`=1 system clock after `cs_n` falls.
- R6: `cs_n` returns high half an `sclk` period after the last falling `sclk` edge, which is `CS_SETUP`+16*`SCK_DIV` clocks after it fell.
- R7: `busy` falls `GAP_CYC`=32 clocks after `cs_n` rises. Between frames `cs_n` stays high for at least `GAP_CYC`+1 clocks.
- R8: `busy` rises on the edge that accepts a request, and `cs_n` falls on that same edge. `cmd` and `data` are captured only on that edge. A request seen while `busy` is high has no effect on the frame in flight or on later timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to send one frame |
| cmd | input | 4 | Command code, captured on acceptance |
| data | input | 12 | Data value, captured on acceptance |
| busy | output | 1 | High from acceptance until the guard interval ends |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out, frame bit 15 first |
| cs_n | output | 1 | Active-low peripheral select |

## Verification
Every output is registered. If a request is accepted on edge k, then `cs_n` falls and `busy` rises on edge k, and the first `sclk` rise lands on edge k+1. Each later `mosi` bit appears on a falling `sclk` edge, 3 clocks after the rise before it. `cs_n` rises on edge k+97, and `busy` falls on edge k+129. The bench holds a behavioural model that counts clocks from acceptance and predicts all four outputs for every cycle. The outputs are compared at the falling system clock edge, half a cycle after each update, so each due value is compared in exactly the cycle it appears. Separate edge-timing counters also measure the select-to-clock setup, the number of `sclk` rises per frame and the idle gap between frames.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/spi_cmd_rstsync.sv
module spi_cmd_rstsync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int HALF     = 3,
  parameter int CS_SETUP = 1,
  parameter int GAP_CYC  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic sclk,
  input  logic all_sent,
  output logic busy,
  output logic load,
  output logic rise,
  output logic fall,
  output logic done
);
  localparam int MAXC  = max3(HALF, CS_SETUP, GAP_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    rise    = 1'b0;
    fall    = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          load    = 1'b1;
          state_d = ST_SETUP;
          cnt_d   = CNT_W'(CS_SETUP - 1);
        end
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          rise    = 1'b1;
          state_d = ST_SHIFT;
          cnt_d   = CNT_W'(HALF - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_SHIFT: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (sclk) begin
          fall  = 1'b1;
          cnt_d = CNT_W'(HALF - 1);
        end else if (all_sent) begin
          done    = 1'b1;
          state_d = ST_GAP;
          cnt_d   = CNT_W'(GAP_CYC - 1);
        end else begin
          rise  = 1'b1;
          cnt_d = CNT_W'(HALF - 1);
        end
      end
      ST_GAP: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  // R4: a level of the serial clock never outlasts half a period
  p_half_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |-> (int'(cnt_q) <= HALF - 1));

  // R7: leaving the guard interval always returns to idle
  p_gap_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_GAP && state_q != ST_GAP) |-> (state_q == ST_IDLE));
endmodule

// File: rtl/spi_cmd_pins.sv
module spi_cmd_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic rise,
  input  logic fall,
  input  logic done,
  output logic sclk,
  output logic cs_n
);
  logic sclk_d, cs_n_d, pin_en;

  assign pin_en = load | rise | fall | done;

  always_comb begin
    sclk_d = sclk;
    cs_n_d = cs_n;
    if (rise) sclk_d = 1'b1;
    if (fall) sclk_d = 1'b0;
    if (load) cs_n_d = 1'b0;
    if (done) cs_n_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk <= 1'b0;
      cs_n <= 1'b1;
    end else if (pin_en) begin
      sclk <= sclk_d;
      cs_n <= cs_n_d;
    end
  end

  // R2: the select is released only with the serial clock low
  p_release_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !sclk);
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               fall,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               mosi,
  output logic               all_sent
);
  localparam int BIT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [BIT_W-1:0]   nbits_q, nbits_d;
  logic               sh_en;

  assign sh_en = load | fall;

  always_comb begin
    sr_d    = sr_q;
    nbits_d = nbits_q;
    if (load) begin
      sr_d    = frame_in;
      nbits_d = '0;
    end else if (fall) begin
      sr_d    = {sr_q[FRAME_W-2:0], 1'b0};
      nbits_d = nbits_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      nbits_q <= '0;
    end else if (sh_en) begin
      sr_q    <= sr_d;
      nbits_q <= nbits_d;
    end
  end

  assign mosi     = sr_q[FRAME_W-1];
  assign all_sent = (nbits_q == BIT_W'(FRAME_W));

  // R4: never more clock periods than frame bits
  p_bits_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(nbits_q) <= FRAME_W);
endmodule

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx #(
  parameter int CMD_W    = 4,
  parameter int DATA_W   = 12,
  parameter int SCK_DIV  = 6,
  parameter int CS_SETUP = 1,
  parameter int GAP_CYC  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n
);
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int HALF    = SCK_DIV / 2;

  logic rst_n_s;
  logic load, rise, fall, done, all_sent;
  logic [FRAME_W-1:0] frame;

  assign frame = {cmd, data};

  spi_cmd_rstsync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  spi_cmd_seq #(
    .HALF     (HALF),
    .CS_SETUP (CS_SETUP),
    .GAP_CYC  (GAP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_req (start_req),
    .sclk      (sclk),
    .all_sent  (all_sent),
    .busy      (busy),
    .load      (load),
    .rise      (rise),
    .fall      (fall),
    .done      (done)
  );

  spi_cmd_pins u_pins (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (load),
    .rise  (rise),
    .fall  (fall),
    .done  (done),
    .sclk  (sclk),
    .cs_n  (cs_n)
  );

  spi_cmd_shifter #(
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (load),
    .fall     (fall),
    .frame_in (frame),
    .mosi     (mosi),
    .all_sent (all_sent)
  );

  // R2: no serial clock activity without the select
  p_sck_low_idle_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    cs_n |-> !sclk);

  // R3: data only moves on a falling serial clock while selected
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cs_n && !$past(cs_n) && !$fell(sclk)) |-> $stable(mosi));

  // R7: a new frame starts only from idle
  p_cs_needs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(cs_n) |-> !$past(busy));

  // R8: busy covers the whole selected interval
  p_busy_covers_cs_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cs_n |-> busy);
endmodule

// File: tb/sim_spi_cmd_tx.sv
module sim_spi_cmd_tx;
  localparam int DIV   = 6;
  localparam int HALF  = DIV / 2;
  localparam int SETUP = 1;
  localparam int GAP   = 32;
  localparam int FEND  = SETUP + 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [3:0]  cmd = '0;
  logic [11:0] data = '0;
  logic busy, sclk, mosi, cs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  spi_cmd_tx #(.CMD_W(4), .DATA_W(12), .SCK_DIV(DIV), .CS_SETUP(SETUP), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(req), .cmd(cmd), .data(data),
    .busy(busy), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  // behavioural reference: clocks since acceptance
  bit          m_act = 0;
  int          m_p = 0;
  logic [15:0] m_frame = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act = 0;
    end else if (m_act) begin
      m_p++;
      if (m_p >= FEND + GAP) m_act = 0;
    end else if (req) begin
      m_act = 1;
      m_p = 0;
      m_frame = {cmd, data};
    end
  end

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %b expected %b", rq, what, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input string rq, input string what, input int act, input int exp, input bit atleast);
    checks++;
    if (atleast ? (act < exp) : (act != exp)) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %s%0d", rq, what, act, atleast ? ">=" : "", exp);
    end
  endtask

  // per-cycle comparison plus edge-timing measurements
  int  t_cs_fall = -1, t_cs_rise = -1, n_rise = 0;
  bit  p_cs = 1, p_sck = 0, seen_first = 0;
  bit  monitor_on = 0;

  always @(negedge clk) begin
    if (monitor_on) begin
      logic e_cs, e_sck, e_mosi, e_busy;
      int b;
      e_cs = 1; e_sck = 0; e_mosi = 0; e_busy = 0;
      if (m_act) begin
        e_busy = (m_p < FEND + GAP);
        if (m_p < FEND) begin
          e_cs = 0;
          e_sck = (m_p >= SETUP) && (((m_p - SETUP) % DIV) < HALF);
          b = (m_p < SETUP + HALF) ? 0 : ((m_p - SETUP - HALF) / DIV + 1);
          e_mosi = (b < 16) ? m_frame[15 - b] : 1'b0;
        end
      end
      chk("R6", "cs_n", cs_n, e_cs);
      chk("R4", "sclk", sclk, e_sck);
      chk("R1", "mosi", mosi, e_mosi);
      chk("R8", "busy", busy, e_busy);
      if (cs_n && sclk) chk("R2", "sclk while deselected", sclk, 1'b0);
      // edge timing
      if (p_cs && !cs_n) begin
        if (t_cs_rise >= 0) chk_int("R7", "deselect gap", cyc - t_cs_rise, GAP + 1, 1);
        t_cs_fall = cyc; n_rise = 0; seen_first = 0;
      end
      if (!cs_n && sclk && !p_sck) begin
        if (!seen_first) chk_int("R5", "select to first sclk", cyc - t_cs_fall, SETUP, 0);
        seen_first = 1;
        n_rise++;
      end
      if (!p_cs && cs_n) begin
        chk_int("R4", "sclk rises per frame", n_rise, 16, 0);
        chk_int("R6", "select length", cyc - t_cs_fall, FEND, 0);
        t_cs_rise = cyc;
      end
      p_cs = cs_n; p_sck = sclk;
    end
  end

  task automatic send(input logic [3:0] c, input logic [11:0] d);
    @(negedge clk);
    req = 1; cmd = c; data = d;
    @(negedge clk);
    while (!busy) @(negedge clk);
    req = 0;
    cmd = ~c; data = ~d;  // R8: changes after acceptance must not reach the frame
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: outputs during reset
    chk("R2", "reset cs_n", cs_n, 1'b1);
    chk("R2", "reset sclk", sclk, 1'b0);
    chk("R2", "reset busy", busy, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R2", "idle mosi", mosi, 1'b0);
    monitor_on = 1;

    send(4'hA, 12'h5C3); wait_idle();
    send(4'hF, 12'hFFF); wait_idle();
    send(4'h0, 12'h000); wait_idle();
    send(4'h1, 12'h801);
    // R8: requests while busy are dropped
    repeat (20) @(negedge clk);
    req = 1; cmd = 4'h7; data = 12'h3E9;
    repeat (5) @(negedge clk);
    req = 0;
    repeat (80) @(negedge clk);
    req = 1; cmd = 4'h6; data = 12'h111;
    repeat (10) @(negedge clk);
    req = 0;
    wait_idle();
    // back-to-back: request held across the guard interval (R7)
    @(negedge clk);
    req = 1; cmd = 4'h9; data = 12'h2A4;
    @(negedge clk);
    while (!busy) @(negedge clk);
    cmd = 4'h5; data = 12'hC3C;
    while (busy) @(negedge clk);
    @(negedge clk);
    req = 0;
    wait_idle();
    repeat (5) @(negedge clk);
    chk("R2", "final idle cs_n", cs_n, 1'b1);
    chk("R2", "final idle busy", busy, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule